// File: doc/BRIEF.md
# Classic-Cycle Bus Master Engine

This block turns simple local commands into non-pipelined Wishbone bus cycles. A requester presents a command: single read, single write, block read, block write or atomic read-modify-write. It gives a start address, a beat count for block commands, write data, a merge mask and three tag values. The engine raises the cycle signal, runs one strobe phase per beat and follows each phase until the slave ends it with ACK, ERR or RTY. It then reports read data and a final status code back to the requester.

A block command and a read-modify-write keep the cycle signal high from the first phase to the last. Between phases the strobe drops for exactly one cycle. During that gap the address advances, or the merged write data is formed. An ERR ends the whole command at once. An RTY ends it with a retry status, and the engine does not repeat the access itself. A new command is taken only while the engine is idle.

Top module: `wbc_master`

## Requirements
- R1: A synchronous reset makes cycle and strobe low after the next clock edge, with `cmd_ready` high and `rsp_done` low.
- R2: Strobe is never high unless cycle is high. Cycle stays high without a break from the first phase of a command to its last phase, so it falls exactly once per command.
- R3: While strobe is high and no termination is present, address, write enable, write data and all three tag outputs keep their values into the next cycle.
- R4: A single read (op code 0) runs one phase with write enable low. On ACK, the slave data appears on `rd_data` with `rd_valid` high in the following cycle. In that same cycle cycle drops and `rsp_done` reports status 0 (OK).
- R5: A single write (op code 1) runs one phase with write enable high, with `wr_data` on the data bus and every select bit high. It ends with status 0.
- R6: A block read (op 2) or block write (op 3) runs `cmd_len`+1 phases. The address starts at `cmd_addr` and grows by DATA_W/8 per beat. One strobe-low gap cycle separates consecutive phases.
- R7: Each ACKed beat of a single or block write gives a one-cycle `wr_take` pulse. For a block write, the data for the next beat is sampled from `wr_data` at the end of the gap cycle that follows.
- R8: A read-modify-write (op 4) reads and then writes the same address under one cycle assertion. It writes (old AND NOT mask) OR (data AND mask), where mask and data are the `cmd_mask` and `wr_data` values latched when the command is accepted.
- R9: An ERR ends the command in the next cycle. No later phase starts, no read data is returned for that beat, and the status is 1 (ERR).
- R10: An RTY ends the command in the next cycle with status 2 (RETRY), and the access is not repeated.
- R11: `cmd_ready` is high only while idle. A command offered while busy has no effect.
- R12: The tag outputs carry the command's address, cycle and data tag values throughout every phase of that command.
- R13: Elaboration is rejected unless DATA_W is 8, 16, 32 or 64. The read and write data buses share that one width, and the select width is DATA_W/8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command will be taken |
| cmd_op | input | 3 | 0 read, 1 write, 2 block read, 3 block write, 4 read-modify-write |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_len | input | LEN_W | Block beats minus one |
| cmd_mask | input | DATA_W | Bits replaced by a read-modify-write |
| cmd_tga | input | TGA_W | Address tag value |
| cmd_tgc | input | TGC_W | Cycle tag value |
| cmd_tgd | input | TGD_W | Data tag value |
| wr_data | input | DATA_W | Write data for the current or next beat |
| wr_take | output | 1 | A write beat was acknowledged |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Captured read data |
| rsp_done | output | 1 | Command finished, one cycle |
| rsp_status | output | 2 | 0 OK, 1 ERR, 2 RETRY |
| wbm_cyc_o | output | 1 | Bus cycle |
| wbm_stb_o | output | 1 | Strobe |
| wbm_we_o | output | 1 | Write enable |
| wbm_adr_o | output | ADDR_W | Address |
| wbm_dat_o | output | DATA_W | Write data |
| wbm_sel_o | output | DATA_W/8 | Byte selects, all ones |
| wbm_tga_o | output | TGA_W | Address tag |
| wbm_tgc_o | output | TGC_W | Cycle tag |
| wbm_tgd_o | output | TGD_W | Data tag |
| wbm_dat_i | input | DATA_W | Read data from slave |
| wbm_ack_i | input | 1 | Normal termination |
| wbm_err_i | input | 1 | Error termination |
| wbm_rty_i | input | 1 | Retry termination |

## Verification
The hardest case to reach is a termination other than ACK in the middle of a multi-phase command, after some beats have already returned data. Only that case shows whether the abort truly stops further phases and drops cycle once. The behavioural slave in the bench counts phases inside the current cycle and can be told to answer one chosen beat with ERR or RTY after a set number of wait states. A block read is therefore stopped on its second beat. A second hard case is a command offered while another is in flight. The bench issues that offer from inside a long wait state, then reads the target address back to show that nothing was written.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

   typedef enum logic [2:0] {
      OP_RD  = 3'd0,
      OP_WR  = 3'd1,
      OP_BRD = 3'd2,
      OP_BWR = 3'd3,
      OP_RMW = 3'd4
   } wbc_op_e;

   typedef enum logic [1:0] {
      STAT_OK  = 2'd0,
      STAT_ERR = 2'd1,
      STAT_RTY = 2'd2
   } wbc_stat_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_PHASE,
      S_GAP
   } wbc_state_e;

endpackage

// File: rtl/wbc_addr_gen.sv
module wbc_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 4,
   parameter int STEP   = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  beats_m1,
   input  logic              adv,
   input  logic              adv_addr,
   output logic [ADDR_W-1:0] addr,
   output logic              last
);
   logic [LEN_W-1:0] left_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         addr   <= '0;
         left_q <= '0;
      end else if (load) begin
         addr   <= base;
         left_q <= beats_m1;
      end else if (adv) begin
         left_q <= left_q - LEN_W'(1);
         if (adv_addr) addr <= addr + ADDR_W'(STEP);
      end
   end

   assign last = (left_q == '0);
endmodule

// File: rtl/wbc_rmw_merge.sv
module wbc_rmw_merge #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] new_val,
   input  logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] merged
);
   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign merged[b] = mask[b] ? new_val[b] : old_val[b];
   end
endmodule

// File: rtl/wbc_master.sv
module wbc_master
   import wbc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 4,
   parameter int TGA_W  = 4,
   parameter int TGC_W  = 4,
   parameter int TGD_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [LEN_W-1:0]  cmd_len,
   input  logic [DATA_W-1:0] cmd_mask,
   input  logic [TGA_W-1:0]  cmd_tga,
   input  logic [TGC_W-1:0]  cmd_tgc,
   input  logic [TGD_W-1:0]  cmd_tgd,
   input  logic [DATA_W-1:0] wr_data,
   output logic              wr_take,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              rsp_done,
   output logic [1:0]        rsp_status,
   output logic              wbm_cyc_o,
   output logic              wbm_stb_o,
   output logic              wbm_we_o,
   output logic [ADDR_W-1:0] wbm_adr_o,
   output logic [DATA_W-1:0] wbm_dat_o,
   output logic [DATA_W/8-1:0] wbm_sel_o,
   output logic [TGA_W-1:0]  wbm_tga_o,
   output logic [TGC_W-1:0]  wbm_tgc_o,
   output logic [TGD_W-1:0]  wbm_tgd_o,
   input  logic [DATA_W-1:0] wbm_dat_i,
   input  logic              wbm_ack_i,
   input  logic              wbm_err_i,
   input  logic              wbm_rty_i
);
   localparam int SEL_W = DATA_W / 8;
   localparam int STEP  = DATA_W / 8;

   // R13: elaboration-time parameter checks
   if (!(DATA_W == 8 || DATA_W == 16 || DATA_W == 32 || DATA_W == 64)) begin : g_bad_dw
      $error("wbc_master: DATA_W must be 8, 16, 32 or 64");
   end
   if (LEN_W < 1 || ADDR_W < 4) begin : g_bad_len
      $error("wbc_master: LEN_W must be >= 1 and ADDR_W >= 4");
   end

   wbc_state_e        state_q;
   wbc_op_e           op_q;
   wbc_stat_e         stat_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] mod_q;
   logic [DATA_W-1:0] merged;
   logic [LEN_W-1:0]  load_len;
   logic              accept, hit_ack, hit_err, hit_rty, last, adv;

   assign cmd_ready = (state_q == S_IDLE);
   assign accept    = cmd_ready && cmd_valid && (cmd_op <= 3'd4);
   assign hit_err   = wbm_stb_o && wbm_err_i;
   assign hit_rty   = wbm_stb_o && wbm_rty_i && !wbm_err_i;
   assign hit_ack   = wbm_stb_o && wbm_ack_i && !wbm_err_i && !wbm_rty_i;
   assign adv       = (state_q == S_PHASE) && hit_ack && !last;
   assign wbm_sel_o = {SEL_W{1'b1}};
   assign rsp_status = stat_q;

   always_comb begin
      case (cmd_op)
         OP_BRD, OP_BWR: load_len = cmd_len;
         OP_RMW:         load_len = LEN_W'(1);
         default:        load_len = '0;
      endcase
   end

   wbc_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .STEP(STEP)) u_addr (
      .clk      (clk),
      .rst      (rst),
      .load     (accept),
      .base     (cmd_addr),
      .beats_m1 (load_len),
      .adv      (adv),
      .adv_addr (op_q != OP_RMW),
      .addr     (wbm_adr_o),
      .last     (last)
   );

   wbc_rmw_merge #(.DATA_W(DATA_W)) u_merge (
      .old_val (rd_data),
      .new_val (mod_q),
      .mask    (mask_q),
      .merged  (merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q   <= S_IDLE;
         op_q      <= OP_RD;
         stat_q    <= STAT_OK;
         mask_q    <= '0;
         mod_q     <= '0;
         wbm_cyc_o <= 1'b0;
         wbm_stb_o <= 1'b0;
         wbm_we_o  <= 1'b0;
         wbm_dat_o <= '0;
         wbm_tga_o <= '0;
         wbm_tgc_o <= '0;
         wbm_tgd_o <= '0;
         rd_valid  <= 1'b0;
         rd_data   <= '0;
         wr_take   <= 1'b0;
         rsp_done  <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         wr_take  <= 1'b0;
         rsp_done <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (accept) begin
                  state_q   <= S_PHASE;
                  op_q      <= wbc_op_e'(cmd_op);
                  wbm_cyc_o <= 1'b1;
                  wbm_stb_o <= 1'b1;
                  wbm_we_o  <= (cmd_op == OP_WR) || (cmd_op == OP_BWR);
                  wbm_dat_o <= wr_data;
                  wbm_tga_o <= cmd_tga;
                  wbm_tgc_o <= cmd_tgc;
                  wbm_tgd_o <= cmd_tgd;
                  mask_q    <= cmd_mask;
                  mod_q     <= wr_data;
               end
            end
            S_PHASE: begin
               if (hit_ack || hit_err || hit_rty) begin
                  wbm_stb_o <= 1'b0;
                  if (hit_ack && !wbm_we_o) begin
                     rd_valid <= 1'b1;
                     rd_data  <= wbm_dat_i;
                  end
                  if (hit_ack && wbm_we_o && op_q != OP_RMW) wr_take <= 1'b1;
                  if (hit_ack && !last) begin
                     state_q <= S_GAP;
                  end else begin
                     state_q   <= S_IDLE;
                     wbm_cyc_o <= 1'b0;
                     rsp_done  <= 1'b1;
                     stat_q    <= hit_err ? STAT_ERR : (hit_rty ? STAT_RTY : STAT_OK);
                  end
               end
            end
            default: begin
               state_q   <= S_PHASE;
               wbm_stb_o <= 1'b1;
               if (op_q == OP_RMW) begin
                  wbm_we_o  <= 1'b1;
                  wbm_dat_o <= merged;
               end else if (op_q == OP_BWR) begin
                  wbm_dat_o <= wr_data;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/wbc_master_chk.sv
module wbc_master_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 32,
   parameter int TGA_W  = 4,
   parameter int TGC_W  = 4,
   parameter int TGD_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cmd_ready,
   input logic              rd_valid,
   input logic              rsp_done,
   input logic [1:0]        rsp_status,
   input logic              wbm_cyc_o,
   input logic              wbm_stb_o,
   input logic              wbm_we_o,
   input logic [ADDR_W-1:0] wbm_adr_o,
   input logic [DATA_W-1:0] wbm_dat_o,
   input logic [TGA_W-1:0]  wbm_tga_o,
   input logic [TGC_W-1:0]  wbm_tgc_o,
   input logic [TGD_W-1:0]  wbm_tgd_o,
   input logic              wbm_ack_i,
   input logic              wbm_err_i,
   input logic              wbm_rty_i
);
   logic term;
   assign term = wbm_ack_i || wbm_err_i || wbm_rty_i;

   a_r1_reset_quiet: assert property (@(posedge clk)
      rst |=> (!wbm_cyc_o && !wbm_stb_o));

   a_r2_stb_in_cyc: assert property (@(posedge clk) disable iff (rst)
      wbm_stb_o |-> wbm_cyc_o);

   a_r3_hold_while_waiting: assert property (@(posedge clk) disable iff (rst)
      (wbm_stb_o && !term) |=> (wbm_stb_o && $stable(wbm_adr_o) && $stable(wbm_dat_o)
         && $stable(wbm_we_o) && $stable(wbm_tga_o) && $stable(wbm_tgc_o)
         && $stable(wbm_tgd_o)));

   a_r4_read_data_source: assert property (@(posedge clk) disable iff (rst)
      rd_valid |-> $past(wbm_stb_o && wbm_ack_i && !wbm_we_o));

   a_r9_err_aborts: assert property (@(posedge clk) disable iff (rst)
      (wbm_stb_o && wbm_err_i) |=> (!wbm_cyc_o && rsp_done && rsp_status == 2'd1));

   a_r10_rty_ends: assert property (@(posedge clk) disable iff (rst)
      (wbm_stb_o && wbm_rty_i && !wbm_err_i) |=> (!wbm_cyc_o && rsp_done && rsp_status == 2'd2));

   a_r11_ready_only_idle: assert property (@(posedge clk) disable iff (rst)
      cmd_ready |-> !wbm_cyc_o);
endmodule

bind wbc_master wbc_master_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TGA_W(TGA_W), .TGC_W(TGC_W), .TGD_W(TGD_W)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cmd_ready  (cmd_ready),
   .rd_valid   (rd_valid),
   .rsp_done   (rsp_done),
   .rsp_status (rsp_status),
   .wbm_cyc_o  (wbm_cyc_o),
   .wbm_stb_o  (wbm_stb_o),
   .wbm_we_o   (wbm_we_o),
   .wbm_adr_o  (wbm_adr_o),
   .wbm_dat_o  (wbm_dat_o),
   .wbm_tga_o  (wbm_tga_o),
   .wbm_tgc_o  (wbm_tgc_o),
   .wbm_tgd_o  (wbm_tgd_o),
   .wbm_ack_i  (wbm_ack_i),
   .wbm_err_i  (wbm_err_i),
   .wbm_rty_i  (wbm_rty_i)
);

// File: tb/tb_wbc_master.sv
module tb_wbc_master;
   localparam int DW = 32, AW = 16, LW = 4, TW = 4;

   logic clk = 1'b0, rst = 1'b1;
   always #10 clk = ~clk;

   logic          cmd_valid = 0, cmd_ready;
   logic [2:0]    cmd_op = 0;
   logic [AW-1:0] cmd_addr = 0;
   logic [LW-1:0] cmd_len = 0;
   logic [DW-1:0] cmd_mask = 0, wr_data = 0;
   logic [TW-1:0] cmd_tga = 0, cmd_tgc = 0, cmd_tgd = 0;
   logic          wr_take, rd_valid, rsp_done;
   logic [DW-1:0] rd_data;
   logic [1:0]    rsp_status;
   logic          cyc, stb, we;
   logic [AW-1:0] adr;
   logic [DW-1:0] dat_o, dat_i;
   logic [3:0]    sel;
   logic [TW-1:0] tga, tgc, tgd;
   logic          s_ack, s_err, s_rty;

   wbc_master #(.DATA_W(DW), .ADDR_W(AW), .LEN_W(LW), .TGA_W(TW), .TGC_W(TW), .TGD_W(TW)) dut (
      .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_mask(cmd_mask), .cmd_tga(cmd_tga),
      .cmd_tgc(cmd_tgc), .cmd_tgd(cmd_tgd), .wr_data(wr_data), .wr_take(wr_take),
      .rd_valid(rd_valid), .rd_data(rd_data), .rsp_done(rsp_done), .rsp_status(rsp_status),
      .wbm_cyc_o(cyc), .wbm_stb_o(stb), .wbm_we_o(we), .wbm_adr_o(adr), .wbm_dat_o(dat_o),
      .wbm_sel_o(sel), .wbm_tga_o(tga), .wbm_tgc_o(tgc), .wbm_tgd_o(tgd),
      .wbm_dat_i(dat_i), .wbm_ack_i(s_ack), .wbm_err_i(s_err), .wbm_rty_i(s_rty));

   // behavioural slave
   int slv_wait = 0, slv_bad_beat = -1;
   bit slv_bad_rty = 0;
   int wcnt = 0, sbeat = 0;
   logic [DW-1:0] mem [16];
   initial for (int i = 0; i < 16; i++) mem[i] = '0;

   always_comb begin
      s_ack = 1'b0; s_err = 1'b0; s_rty = 1'b0;
      if (stb && wcnt == slv_wait) begin
         if (sbeat == slv_bad_beat) begin
            if (slv_bad_rty) s_rty = 1'b1; else s_err = 1'b1;
         end else s_ack = 1'b1;
      end
   end
   assign dat_i = mem[adr[5:2]];

   always @(posedge clk) begin
      if (!stb || s_ack || s_err || s_rty) wcnt <= 0; else wcnt <= wcnt + 1;
      if (!cyc) sbeat <= 0; else if (stb && (s_ack || s_err || s_rty)) sbeat <= sbeat + 1;
      if (stb && s_ack && we) mem[adr[5:2]] <= dat_o;
   end

   // bus monitor
   int ph_n = 0, gap_n = 0, fall_n = 0, hold_bad = 0, tag_bad = 0, sel_bad = 0, nocyc_bad = 0;
   logic [AW-1:0] ph_adr [64];
   logic          ph_we  [64];
   logic [DW-1:0] ph_dat [64];
   logic          prev_cyc = 0, p_hold = 0, p_we = 0;
   logic [AW-1:0] p_adr = 0;
   logic [DW-1:0] p_dat = 0;
   logic [TW-1:0] p_tga = 0, p_tgc = 0, p_tgd = 0;
   logic [TW-1:0] exp_tga = 0, exp_tgc = 0, exp_tgd = 0;

   always @(posedge clk) begin
      if (rst) begin
         p_hold <= 1'b0;
         prev_cyc <= 1'b0;
      end else begin
         if (p_hold && (adr != p_adr || dat_o != p_dat || we != p_we ||
                        tga != p_tga || tgc != p_tgc || tgd != p_tgd || !stb))
            hold_bad <= hold_bad + 1;
         p_hold <= stb && !(s_ack || s_err || s_rty);
         p_adr <= adr; p_dat <= dat_o; p_we <= we;
         p_tga <= tga; p_tgc <= tgc; p_tgd <= tgd;
         if (stb && !cyc) nocyc_bad <= nocyc_bad + 1;
         if (stb && (tga != exp_tga || tgc != exp_tgc || tgd != exp_tgd)) tag_bad <= tag_bad + 1;
         if (stb && sel != 4'hF) sel_bad <= sel_bad + 1;
         if (cyc && !stb) gap_n <= gap_n + 1;
         if (prev_cyc && !cyc) fall_n <= fall_n + 1;
         prev_cyc <= cyc;
         if (stb && (s_ack || s_err || s_rty)) begin
            ph_adr[ph_n % 64] <= adr;
            ph_we[ph_n % 64]  <= we;
            ph_dat[ph_n % 64] <= dat_o;
            ph_n <= ph_n + 1;
         end
      end
   end

   // scoring
   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // per-command results
   int r_stat, r_rd_n, r_ph, r_gap, r_fall, r_wt, r_p0, r_busy_ready;
   logic [DW-1:0] rd_buf [16];
   logic [DW-1:0] bw [8];

   task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a, input logic [LW-1:0] len,
                          input logic [DW-1:0] mask, input bit poke);
      int p0, g0, f0, bi, cyc_i;
      @(negedge clk);
      exp_tga = a[5:2]; exp_tgc = {1'b0, op}; exp_tgd = ~a[5:2];
      cmd_op = op; cmd_addr = a; cmd_len = len; cmd_mask = mask;
      cmd_tga = exp_tga; cmd_tgc = exp_tgc; cmd_tgd = exp_tgd;
      bi = 0; wr_data = bw[0];
      p0 = ph_n; g0 = gap_n; f0 = fall_n;
      r_rd_n = 0; r_wt = 0; r_stat = -1; r_busy_ready = 0;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      cyc_i = 0;
      while (cyc_i < 300) begin
         if (poke && cyc_i == 1) begin
            r_busy_ready = cmd_ready;
            cmd_op = 3'd1; cmd_addr = 16'h003C; wr_data = 32'h0BAD_0BAD; cmd_valid = 1'b1;
         end else begin
            cmd_valid = 1'b0;
         end
         if (wr_take) begin
            r_wt++;
            bi++;
            if (bi < 8) wr_data = bw[bi];
         end
         if (rd_valid) begin
            rd_buf[r_rd_n % 16] = rd_data;
            r_rd_n++;
         end
         if (rsp_done) begin
            r_stat = rsp_status;
            break;
         end
         @(negedge clk);
         cyc_i++;
      end
      cmd_valid = 1'b0;
      @(negedge clk);
      r_ph = ph_n - p0; r_gap = gap_n - g0; r_fall = fall_n - f0; r_p0 = p0;
   endtask

   task automatic slave_cfg(input int w, input int bad, input bit rty);
      slv_wait = w; slv_bad_beat = bad; slv_bad_rty = rty;
   endtask

   task automatic t_reset;
      check(cyc == 1'b0 && stb == 1'b0, "R1 reset cyc/stb", {cyc, stb}, 0);
      check(cmd_ready == 1'b1, "R1 reset ready", cmd_ready, 1);
      check(rsp_done == 1'b0, "R1 reset done", rsp_done, 0);
   endtask

   task automatic t_single_write;
      slave_cfg(2, -1, 0);
      bw[0] = 32'hA5A5_0001;
      run_cmd(3'd1, 16'h0008, 0, 0, 0);
      check(r_stat == 0, "R5 write status", r_stat, 0);
      check(mem[2] == 32'hA5A5_0001, "R5 write stored", mem[2], 32'hA5A5_0001);
      check(r_ph == 1 && ph_we[r_p0 % 64] == 1'b1, "R5 one write phase", r_ph, 1);
      check(r_wt == 1, "R7 single write take", r_wt, 1);
      check(r_fall == 1, "R2 single cyc fall", r_fall, 1);
   endtask

   task automatic t_single_read;
      slave_cfg(0, -1, 0);
      run_cmd(3'd0, 16'h0008, 0, 0, 0);
      check(r_stat == 0, "R4 read status", r_stat, 0);
      check(r_rd_n == 1 && rd_buf[0] == 32'hA5A5_0001, "R4 read data", rd_buf[0], 32'hA5A5_0001);
      check(r_ph == 1 && ph_we[r_p0 % 64] == 1'b0, "R4 read phase", r_ph, 1);
   endtask

   task automatic t_block_write;
      bit ok;
      slave_cfg(1, -1, 0);
      for (int i = 0; i < 4; i++) bw[i] = {16'h1111 * (i + 1), 16'(i)};
      run_cmd(3'd3, 16'h0010, 3, 0, 0);
      check(r_stat == 0, "R6 block write status", r_stat, 0);
      check(r_ph == 4, "R6 block write phases", r_ph, 4);
      check(r_gap == 3, "R6 block write gaps", r_gap, 3);
      check(r_fall == 1, "R2 block single cyc", r_fall, 1);
      check(r_wt == 4, "R7 take pulses", r_wt, 4);
      ok = 1;
      for (int i = 0; i < 4; i++) begin
         if (ph_adr[(r_p0 + i) % 64] != AW'(16 + 4 * i)) ok = 0;
         if (mem[4 + i] != bw[i]) ok = 0;
      end
      check(ok, "R7 block write data/addr", mem[5], bw[1]);
   endtask

   task automatic t_block_read;
      bit ok;
      slave_cfg(3, -1, 0);
      run_cmd(3'd2, 16'h0010, 3, 0, 0);
      check(r_stat == 0 && r_ph == 4, "R6 block read phases", r_ph, 4);
      ok = (r_rd_n == 4);
      for (int i = 0; i < 4; i++) if (rd_buf[i] != bw[i]) ok = 0;
      check(ok, "R6 block read data", rd_buf[3], bw[3]);
   endtask

   task automatic t_rmw;
      slave_cfg(1, -1, 0);
      bw[0] = 32'h1234_5678;
      run_cmd(3'd4, 16'h0010, 0, 32'h0000_FFFF, 0);
      check(r_stat == 0 && r_ph == 2, "R8 rmw phases", r_ph, 2);
      check(ph_we[r_p0 % 64] == 0 && ph_we[(r_p0 + 1) % 64] == 1 &&
            ph_adr[(r_p0 + 1) % 64] == 16'h0010, "R8 rmw order/addr", ph_adr[(r_p0 + 1) % 64], 16'h0010);
      check(r_fall == 1, "R8 rmw one cyc", r_fall, 1);
      check(mem[4] == 32'h1111_5678, "R8 rmw merge", mem[4], 32'h1111_5678);
   endtask

   task automatic t_err;
      slave_cfg(1, 1, 0);
      run_cmd(3'd2, 16'h0010, 3, 0, 0);
      check(r_stat == 1, "R9 err status", r_stat, 1);
      check(r_ph == 2 && r_gap == 1, "R9 err abort phases", r_ph, 2);
      check(r_rd_n == 1 && rd_buf[0] == 32'h1111_5678, "R9 err data count", r_rd_n, 1);
   endtask

   task automatic t_rty;
      slave_cfg(2, 0, 1);
      bw[0] = 32'hDEAD_BEEF;
      run_cmd(3'd1, 16'h000C, 0, 0, 0);
      check(r_stat == 2, "R10 rty status", r_stat, 2);
      check(r_ph == 1 && r_wt == 0, "R10 no repeat", r_ph, 1);
      check(mem[3] == 32'h0, "R10 nothing written", mem[3], 0);
   endtask

   task automatic t_busy;
      slave_cfg(4, -1, 0);
      run_cmd(3'd2, 16'h0018, 1, 0, 1);
      check(r_busy_ready == 0, "R11 not ready busy", r_busy_ready, 0);
      check(r_ph == 2 && r_stat == 0, "R11 busy phases", r_ph, 2);
      slave_cfg(0, -1, 0);
      run_cmd(3'd0, 16'h003C, 0, 0, 0);
      check(rd_buf[0] == 32'h0, "R11 offer ignored", rd_buf[0], 0);
   endtask

   task automatic t_reset_mid;
      slave_cfg(5, -1, 0);
      @(negedge clk);
      cmd_op = 3'd2; cmd_addr = 16'h0010; cmd_len = 3; cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(cyc == 1'b1, "R1 busy before reset", cyc, 1);
      rst = 1'b1;
      @(negedge clk);
      check(cyc == 1'b0 && stb == 1'b0 && cmd_ready == 1'b1, "R1 mid reset", {cyc, stb, cmd_ready}, 1);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      t_reset();
      t_single_write();
      t_single_read();
      t_block_write();
      t_block_read();
      t_rmw();
      t_err();
      t_rty();
      t_busy();
      t_reset_mid();
      check(hold_bad == 0, "R3 held while waiting", hold_bad, 0);
      check(nocyc_bad == 0, "R2 stb without cyc", nocyc_bad, 0);
      check(tag_bad == 0, "R12 tags", tag_bad, 0);
      check(sel_bad == 0, "R13 select all ones", sel_bad, 0);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule